// File: doc/BRIEF.md
# Resolution-Scaled Conversion Sequencer

This block paces temperature conversions for a thermometer and thermostat. It counts ticks of an input millisecond strobe. When enough ticks have passed for the selected resolution, it captures a raw 16-bit two's complement sample into a result register and pulses a completion strobe for the thermostat logic downstream. Each resolution step adds one bit of precision and doubles the conversion period. Result bits below the selected precision are cleared when the sample is captured.

Conversions run back to back from reset without any command. A shutdown request never cuts a conversion short. The conversion in flight finishes and stores its result, and only then does the sequencer go idle. Clearing the request starts a fresh conversion.

The result leaves the block as a valid-only stream. `done` is the valid, and there is no ready. The consumer cannot apply back-pressure and must take each strobe in the cycle it appears. `result` holds its value until the next strobe, so it can be read at any time without disturbing the conversion in progress.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, `result` is 0 and `done` is low. A conversion starts at once with no command, and the first one uses 9-bit resolution (code 00) whatever `res_sel` holds.
- R2: A conversion takes BASE_TICKS shifted left by the resolution code, counted in ticks. With the default of 25, code 00 takes 25 ticks, 01 takes 50, 10 takes 100 and 11 takes 200.
- R3: Bits 3 to 0 of `result` are always zero.
- R4: `done` is high for exactly one cycle, in the cycle after the clock edge that samples the final tick of a conversion. `result` takes its new value on that same edge.
- R5: Between strobes, `result` holds its value, whatever `sample` does.
- R6: For code c, the captured value keeps the top 9+c bits of `sample`, including the sign in bit 15, and zeroes the rest. Code 00 keeps bits 15 to 7, and code 11 keeps bits 15 to 4.
- R7: The resolution code applied to a conversion is the value `res_sel` holds in the cycle the previous conversion completes, or the cycle the sequencer leaves standby. A change in the middle of a conversion does not alter that conversion's length or mask.
- R8: When `shutdown` is high in the cycle a conversion completes, including when it rises in that very cycle, the result is still captured and strobed. After that no further `done` occurs while `shutdown` stays high.
- R9: When `shutdown` goes low in standby, a new conversion begins on the next edge. Its resolution is taken from `res_sel` at that moment, and it runs a full period.
- R10: A conversion advances only on cycles where `ms_tick` is high. Without ticks, no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond tick that advances the conversion timer |
| res_sel | input | 2 | Resolution code: 00 is 9 bits, 01 is 10, 10 is 11, 11 is 12 |
| shutdown | input | 1 | Request to stop after the current conversion |
| sample | input | 16 | Raw two's complement temperature word |
| result | output | 16 | Latest captured, masked result |
| done | output | 1 | One-cycle strobe (stream valid) marking a new result |

## Verification
The completion of a conversion can fall in the same cycle as a change of control. Both a rising `shutdown` and a new `res_sel` code can arrive together with the final tick. The bench drives them on the same edge as that tick. It then judges the outcome on what follows at the ports. The strobe and masked result must still appear. With shutdown, the strobes must stop for a long run of ticks. With a new code, the following conversion must run the period of the new code.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic {
    SEQ_CONVERT = 1'b0,
    SEQ_STANDBY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  // final tick of the period ends the conversion
  assign expire = run && tick && (cnt == period - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= expire ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int RES_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic             shutdown,
  input  logic [RES_W-1:0] res_sel,
  output logic             run,
  output logic             standby,
  output logic [RES_W-1:0] res_act
);
  seq_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_CONVERT;
      res_act <= '0;
    end else begin
      unique case (state)
        SEQ_CONVERT: begin
          if (expire) begin
            if (shutdown) state <= SEQ_STANDBY;
            else          res_act <= res_sel;
          end
        end
        SEQ_STANDBY: begin
          if (!shutdown) begin
            state   <= SEQ_CONVERT;
            res_act <= res_sel;
          end
        end
        default: state <= SEQ_CONVERT;
      endcase
    end
  end

  assign run     = (state == SEQ_CONVERT);
  assign standby = (state == SEQ_STANDBY);
endmodule

// File: rtl/result_latch.sv
module result_latch #(
  parameter int DATA_W   = 16,
  parameter int MIN_BITS = 9,
  parameter int RES_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [RES_W-1:0]  res_act,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  localparam int NUM_RES = 1 << RES_W;

  logic [DATA_W-1:0] mask_tbl [NUM_RES];

  for (genvar g = 0; g < NUM_RES; g++) begin : g_mask
    assign mask_tbl[g] = {DATA_W{1'b1}} << (DATA_W - MIN_BITS - g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= capture;
      if (capture) result <= sample & mask_tbl[res_act];
    end
  end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int DATA_W     = 16,
  parameter int MIN_BITS   = 9,
  parameter int RES_W      = 2,
  parameter int BASE_TICKS = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic [RES_W-1:0]  res_sel,
  input  logic              shutdown,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  localparam int MAX_TICKS = BASE_TICKS << ((1 << RES_W) - 1);
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic             run;
  logic             standby;
  logic             expire;
  logic [RES_W-1:0] res_act;
  logic [CNT_W-1:0] period;

  assign period = CNT_W'(BASE_TICKS) << res_act;

  seq_ctrl #(.RES_W(RES_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .expire(expire), .shutdown(shutdown),
    .res_sel(res_sel), .run(run), .standby(standby), .res_act(res_act)
  );

  tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(ms_tick),
    .period(period), .expire(expire)
  );

  result_latch #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .RES_W(RES_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .capture(expire), .res_act(res_act),
    .sample(sample), .result(result), .done(done)
  );
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ms_tick,
  input logic              shutdown,
  input logic              standby,
  input logic              done,
  input logic [DATA_W-1:0] result
);
  a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_low_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
    result[3:0] == 4'h0);

  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  a_r8_quiet_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && $past(standby)) |-> !done);

  a_r8_standby_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && shutdown) |=> standby);

  a_r9_leave_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !shutdown) |=> !standby);

  a_r10_done_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ms_tick));
endmodule

bind conv_sequencer conv_sequencer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .shutdown(shutdown),
  .standby(standby), .done(done), .result(result)
);

// File: tb/conv_sequencer_test.sv
`timescale 1ns/1ps
module conv_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ms_tick = 1'b0;
  logic [1:0]  res_sel = 2'b00;
  logic        shutdown = 1'b0;
  logic [15:0] sample = 16'h0000;
  logic [15:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;

  always #4 clk = ~clk;

  conv_sequencer uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .res_sel(res_sel),
    .shutdown(shutdown), .sample(sample), .result(result), .done(done)
  );

  always @(negedge clk) if (rst_n && done) done_cnt++;

  task automatic chk16(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkint(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
    #1;
  endtask

  // full conversion, no control change at the boundary
  task automatic conv(string req, int n, logic [15:0] smp, logic [15:0] exp);
    int c0 = done_cnt;
    sample = smp;
    run_ticks(n - 1);
    chkint({req, " no early strobe"}, done_cnt, c0);
    run_ticks(1);
    chkint({req, " strobe"}, done_cnt, c0 + 1);
    chk16({req, " value"}, result, exp);
  endtask

  // final tick coincides with new res_sel / shutdown
  task automatic conv_edge(string req, int n, logic [15:0] smp, logic [15:0] exp,
                           logic [1:0] nres, logic nsd);
    int c0 = done_cnt;
    sample = smp;
    run_ticks(n - 1);
    chkint({req, " no early strobe"}, done_cnt, c0);
    @(negedge clk);
    ms_tick = 1'b1; res_sel = nres; shutdown = nsd;
    @(negedge clk) ms_tick = 1'b0;
    #1;
    chkint({req, " strobe"}, done_cnt, c0 + 1);
    chk16({req, " value"}, result, exp);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk16("R1 reset result", result, 16'h0000);
    chkint("R1 reset done", int'(done), 0);
  endtask

  task automatic t_first_default;
    res_sel = 2'b11;  // ignored for the first conversion
    conv("R1 R6 first 9-bit", 25, 16'h123F, 16'h1200);
    chk16("R3 low nibble", {12'h000, result[3:0]}, 16'h0000);
  endtask

  task automatic t_no_tick_hold;
    int c0 = done_cnt;
    // second conversion uses code 11 (captured at first completion); restore 00
    res_sel = 2'b00;
    sample = 16'hABCD;
    repeat (300) @(negedge clk);
    #1;
    chkint("R10 no strobe without ticks", done_cnt, c0);
    chk16("R5 result held", result, 16'h1200);
    conv_edge("R7 R2 12-bit", 200, 16'h7D0F, 16'h7D00, 2'b01, 1'b0);
  endtask

  task automatic t_resolution_steps;
    conv_edge("R2 R6 10-bit", 50, 16'h0A2F, 16'h0A00, 2'b10, 1'b0);
    conv_edge("R2 R6 11-bit", 100, 16'hF5EF, 16'hF5E0, 2'b11, 1'b0);
  endtask

  task automatic t_mid_change;
    int c0 = done_cnt;
    sample = 16'h1919;
    run_ticks(100);
    res_sel = 2'b00;
    run_ticks(99);
    chkint("R7 mid change keeps period", done_cnt, c0);
    run_ticks(1);
    chkint("R7 strobe at 200", done_cnt, c0 + 1);
    chk16("R6 R7 12-bit mask kept", result, 16'h1910);
    conv("R7 next uses new code", 25, 16'hFFFF, 16'hFF80);
  endtask

  task automatic t_shutdown_edge;
    int c0;
    conv_edge("R8 coincident shutdown", 25, 16'hC90F, 16'hC900, 2'b00, 1'b1);
    c0 = done_cnt;
    sample = 16'h0123;
    run_ticks(80);
    chkint("R8 standby no strobe", done_cnt, c0);
    chk16("R5 R8 result kept", result, 16'hC900);
  endtask

  task automatic t_resume;
    @(negedge clk);
    res_sel = 2'b01; shutdown = 1'b0;
    conv("R9 resume 10-bit", 50, 16'hFF9F, 16'hFF80);
  endtask

  task automatic t_shutdown_mid;
    int c0 = done_cnt;
    sample = 16'h0080;
    run_ticks(10);
    shutdown = 1'b1;
    run_ticks(39);
    chkint("R8 in-flight not cut", done_cnt, c0);
    run_ticks(1);
    chkint("R8 in-flight strobe", done_cnt, c0 + 1);
    chk16("R8 in-flight value", result, 16'h0080);
    run_ticks(60);
    chkint("R8 idle after", done_cnt, c0 + 1);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_first_default();
    t_no_tick_hold();
    t_resolution_steps();
    t_mid_change();
    t_shutdown_edge();
    t_resume();
    t_shutdown_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule